// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Controller

This block watches a narrow input port and raises one interrupt line when an enabled pin meets its trigger condition. Each pin has a mode bit. In one mode the pin triggers when it differs from its own value one clock earlier, so either edge triggers. In the other mode the pin triggers when its level is the opposite of a programmable default bit. Pin inputs are first passed through a synchronizer of configurable depth.

When the interrupt fires, the block takes a snapshot of the whole port and records which enabled pins caused it. Both are held unchanged until software reads either the snapshot register or the live port register. That read clears the pending interrupt and arms detection again. A pin in default mode that still differs from its default raises the interrupt again one cycle after the clearing read. The level of the interrupt output is chosen by a configuration bit, and software reaches all of this through a simple synchronous register port.

Top module: `gpio_ioc_ctrl`

## Requirements
- R1: A pin whose enable bit (register address 0, bit i for pin i) is 0 never raises the interrupt, whatever its level does.
- R2: With mode bit i = 0 (register address 1), pin i triggers on any change of its synchronized level, rising or falling.
- R3: With mode bit i = 1, pin i triggers whenever its synchronized level is the inverse of default bit i (register address 2). A default bit of 0 means a high level triggers.
- R4: When the interrupt is raised, the snapshot register (address 5) takes the port value of that cycle, and the cause register (address 4, read-only) takes one bit set for each enabled pin that triggered.
- R5: While the interrupt is pending, pin activity does not alter the snapshot, the cause register or the interrupt output.
- R6: A read of address 5 or address 6 clears the pending interrupt and the cause register. Reads of other addresses clear nothing.
- R7: In default mode, a pin still opposite its default after the clearing read makes the interrupt pending again on the next cycle, with a new snapshot. The interrupt stays inactive only after a clearing read made while the pin equals its default.
- R8: Configuration bit 0 (address 3) chooses the output level. When it is 0, the output is low while pending and high when idle. When it is 1, the output is high while pending.
- R9: If a clearing read and a new trigger fall in the same cycle, the clear comes first. The interrupt is inactive for one cycle and becomes pending on the next cycle, with the cause bits of that trigger.
- R10: After reset, the enable, mode, default, configuration, snapshot and cause registers read 0, and the interrupt output is high (inactive).
- R11: Addresses 0 to 3 read back what was written to them. Address 6 returns the synchronized live port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | Asynchronous port inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (reads of address 5 or 6 clear) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt output, level chosen by configuration bit 0 |

## Verification
The clearing read and a fresh pin change can land in the same clock cycle. The bench provokes this by counting the synchronizer edges after a pin change and asserting a snapshot read in exactly the cycle where the synchronized level first differs from the previous sample. It then expects the interrupt to be inactive for that one following cycle, to be pending again on the next cycle, and to have a cause register holding only the pin that changed. A second case of the same kind is the default-mode re-raise: the clear and a still-true default mismatch meet, and the snapshot must be taken again.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;

   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_ENABLE  = 3'd0,
      RA_MODE    = 3'd1,
      RA_DEFAULT = 3'd2,
      RA_CONFIG  = 3'd3,
      RA_CAUSE   = 3'd4,
      RA_SNAP    = 3'd5,
      RA_LIVE    = 3'd6
   } reg_addr_e;

   function automatic logic is_clearing_read(input logic [REG_ADDR_W-1:0] a);
      return (a == RA_SNAP) || (a == RA_LIVE);
   endfunction

endpackage

// File: rtl/gpio_ioc_sync.sv
module gpio_ioc_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_ioc_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_ioc_detect.sv
module gpio_ioc_detect #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] pin_s_i,
   input  logic [WIDTH-1:0] ena_i,
   input  logic [WIDTH-1:0] mode_i,
   input  logic [WIDTH-1:0] dflt_i,
   output logic [WIDTH-1:0] hit_o
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= pin_s_i;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic ref_bit;
      always_comb begin
         ref_bit  = mode_i[i] ? dflt_i[i] : prev_q[i];
         hit_o[i] = ena_i[i] && (pin_s_i[i] != ref_bit);
      end
   end

   // R1
   disabled_pin_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o & ~ena_i) == '0);

endmodule

// File: rtl/gpio_ioc_capture.sv
module gpio_ioc_capture #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] pin_s_i,
   input  logic [WIDTH-1:0] hit_i,
   input  logic             clr_i,
   output logic             pending_o,
   output logic [WIDTH-1:0] snap_o,
   output logic [WIDTH-1:0] cause_o
);

   logic             pending_q;
   logic [WIDTH-1:0] snap_q;
   logic [WIDTH-1:0] cause_q;
   logic [WIDTH-1:0] defer_q;
   logic [WIDTH-1:0] raise;

   // a trigger seen in a clearing cycle is held one cycle so it is not lost
   assign raise = hit_i | defer_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pending_q <= 1'b0;
         snap_q    <= '0;
         cause_q   <= '0;
         defer_q   <= '0;
      end else begin
         defer_q <= clr_i ? hit_i : '0;
         if (clr_i) begin
            pending_q <= 1'b0;
            cause_q   <= '0;
         end else if (!pending_q && (raise != '0)) begin
            pending_q <= 1'b1;
            snap_q    <= pin_s_i;
            cause_q   <= raise;
         end
      end
   end

   assign pending_o = pending_q;
   assign snap_o    = snap_q;
   assign cause_o   = cause_q;

   // R4
   snap_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pending_q) |-> snap_q == $past(pin_s_i));

   // R5
   frozen_while_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pending_q && !clr_i) |=> ($stable(snap_q) && $stable(cause_q) && pending_q));

   // R6
   read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !pending_q && (cause_q == '0));

   // R4
   cause_matches_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pending_q == (cause_q != '0));

   // R9
   clear_then_detect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && (hit_i != '0)) ##1 !clr_i |=> pending_q);

endmodule

// File: rtl/gpio_ioc_regs.sv
module gpio_ioc_regs
   import gpio_ioc_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_i,
   input  logic                  rd_i,
   input  logic [REG_ADDR_W-1:0] addr_i,
   input  logic [WIDTH-1:0]      wdata_i,
   input  logic [WIDTH-1:0]      pin_s_i,
   input  logic [WIDTH-1:0]      snap_i,
   input  logic [WIDTH-1:0]      cause_i,
   output logic [WIDTH-1:0]      ena_o,
   output logic [WIDTH-1:0]      mode_o,
   output logic [WIDTH-1:0]      dflt_o,
   output logic                  pol_high_o,
   output logic [WIDTH-1:0]      rdata_o,
   output logic                  clr_o
);

   logic [WIDTH-1:0] ena_q, mode_q, dflt_q;
   logic             pol_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ena_q  <= '0;
         mode_q <= '0;
         dflt_q <= '0;
         pol_q  <= 1'b0;
      end else if (wr_i) begin
         case (addr_i)
            RA_ENABLE:  ena_q  <= wdata_i;
            RA_MODE:    mode_q <= wdata_i;
            RA_DEFAULT: dflt_q <= wdata_i;
            RA_CONFIG:  pol_q  <= wdata_i[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr_i)
         RA_ENABLE:  rdata_o = ena_q;
         RA_MODE:    rdata_o = mode_q;
         RA_DEFAULT: rdata_o = dflt_q;
         RA_CONFIG:  rdata_o = {{(WIDTH-1){1'b0}}, pol_q};
         RA_CAUSE:   rdata_o = cause_i;
         RA_SNAP:    rdata_o = snap_i;
         RA_LIVE:    rdata_o = pin_s_i;
         default:    rdata_o = '0;
      endcase
   end

   assign clr_o      = rd_i && is_clearing_read(addr_i);
   assign ena_o      = ena_q;
   assign mode_o     = mode_q;
   assign dflt_o     = dflt_q;
   assign pol_high_o = pol_q;

   // R11
   write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == RA_ENABLE) |=> ena_q == $past(wdata_i));

endmodule

// File: rtl/gpio_ioc_ctrl.sv
module gpio_ioc_ctrl
   import gpio_ioc_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_OUT_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [PORT_W-1:0] pins_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [2:0]        reg_addr_i,
   input  logic [PORT_W-1:0] reg_wdata_i,
   output logic [PORT_W-1:0] reg_rdata_o,
   output logic              irq_o
);

   if (PORT_W < 2 || PORT_W > 32) begin : g_bad_width
      $error("gpio_ioc_ctrl: PORT_W must lie in 2..32");
   end

   logic [PORT_W-1:0] pin_s, ena, mode, dflt, hit, snap, cause;
   logic              pol_high, clr, pending, irq_level;

   gpio_ioc_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pins_i),
      .q_o   (pin_s)
   );

   gpio_ioc_detect #(.WIDTH(PORT_W)) detect_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_s_i(pin_s),
      .ena_i  (ena),
      .mode_i (mode),
      .dflt_i (dflt),
      .hit_o  (hit)
   );

   gpio_ioc_capture #(.WIDTH(PORT_W)) capture_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_s_i  (pin_s),
      .hit_i    (hit),
      .clr_i    (clr),
      .pending_o(pending),
      .snap_o   (snap),
      .cause_o  (cause)
   );

   gpio_ioc_regs #(.WIDTH(PORT_W)) regs_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (reg_wr_i),
      .rd_i      (reg_rd_i),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .pin_s_i   (pin_s),
      .snap_i    (snap),
      .cause_i   (cause),
      .ena_o     (ena),
      .mode_o    (mode),
      .dflt_o    (dflt),
      .pol_high_o(pol_high),
      .rdata_o   (reg_rdata_o),
      .clr_o     (clr)
   );

   assign irq_level = pol_high ? pending : ~pending;

   if (IRQ_OUT_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b1;
         else         irq_q <= irq_level;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_level;
   end

   // R8
   idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pending && !IRQ_OUT_REG) |-> irq_o == ~pol_high);

endmodule

// File: tb/gpio_ioc_ctrl_tb.sv
module gpio_ioc_ctrl_tb_top;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pins = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;
   logic       pol = 1'b0;
   int         total = 0, failed = 0;
   bit         done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   gpio_ioc_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
      .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_irq(input string req, input bit active);
      check(req, {7'd0, irq}, {7'd0, (pol ? active : !active)});
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pins(input logic [7:0] v);
      @(negedge clk); pins = v;
      settle(4);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         failed++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] dv, pv;
      #1 check_irq("R10 idle before reset release", 1'b0);
      settle(3);
      rst_n = 1'b1;
      settle(2);
      // R10 reset values
      rd_reg(3'd0, d); check("R10 enable", d, 8'h00);
      rd_reg(3'd1, d); check("R10 mode", d, 8'h00);
      rd_reg(3'd2, d); check("R10 default", d, 8'h00);
      rd_reg(3'd3, d); check("R10 config", d, 8'h00);
      rd_reg(3'd4, d); check("R10 cause", d, 8'h00);
      rd_reg(3'd5, d); check("R10 snapshot", d, 8'h00);
      check_irq("R10 irq inactive", 1'b0);

      // R11 readback and live port, R1 with everything disabled
      wr_reg(3'd1, 8'h3C); rd_reg(3'd1, d); check("R11 mode readback", d, 8'h3C);
      wr_reg(3'd2, 8'hC3); rd_reg(3'd2, d); check("R11 default readback", d, 8'hC3);
      wr_reg(3'd0, 8'h00);
      set_pins(8'hA5);
      rd_reg(3'd6, d); check("R11 live port", d, 8'hA5);
      check_irq("R1 disabled pins quiet", 1'b0);
      set_pins(8'h5A);
      check_irq("R1 disabled pins quiet after change", 1'b0);
      wr_reg(3'd1, 8'h00); wr_reg(3'd2, 8'h00);

      // R2/R1/R4/R6 sweep: one enabled pin against every toggled pin, change mode
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            wr_reg(3'd0, 8'h00);
            set_pins(8'h00);
            rd_reg(3'd5, d);
            wr_reg(3'd0, 8'(1 << i));
            settle(2);
            set_pins(8'(1 << j));
            check_irq("R1 R2 rising", i == j);
            if (i == j) begin
               rd_reg(3'd4, d); check("R4 cause", d, 8'(1 << i));
               check_irq("R6 cause read keeps pending", 1'b1);
               rd_reg(3'd5, d); check("R4 snapshot", d, 8'(1 << j));
               check_irq("R6 snapshot read clears", 1'b0);
               set_pins(8'h00);
               check_irq("R2 falling edge", 1'b1);
               rd_reg(3'd6, d); check("R6 live read value", d, 8'h00);
               check_irq("R6 live read clears", 1'b0);
            end
         end
      end

      // R5 freeze while pending
      wr_reg(3'd0, 8'h00); set_pins(8'h00); rd_reg(3'd5, d);
      wr_reg(3'd0, 8'hFF); settle(2);
      set_pins(8'h01);
      set_pins(8'h03);
      set_pins(8'h07);
      check_irq("R5 still pending", 1'b1);
      rd_reg(3'd4, d); check("R5 cause frozen", d, 8'h01);
      rd_reg(3'd5, d); check("R5 snapshot frozen", d, 8'h01);
      settle(2);
      check_irq("R5 quiet after clear", 1'b0);
      rd_reg(3'd4, d); check("R6 cause cleared", d, 8'h00);

      // R3/R7 default mode sweep
      wr_reg(3'd1, 8'hFF);
      for (int k = 0; k < 4; k++) begin
         dv = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : (k == 2) ? 8'hFF : 8'h81;
         for (int p = 0; p < 16; p++) begin
            pv = dv ^ 8'(p * 17);
            wr_reg(3'd0, 8'h00);
            wr_reg(3'd2, dv);
            set_pins(dv);
            rd_reg(3'd5, d);
            wr_reg(3'd0, 8'hFF);
            settle(2);
            set_pins(pv);
            check_irq("R3 opposite of default", pv != dv);
            if (pv != dv) begin
               rd_reg(3'd4, d); check("R3 cause bits", d, pv ^ dv);
               rd_reg(3'd6, d);
               settle(1);
               check_irq("R7 re-raise while differing", 1'b1);
               set_pins(dv);
               check_irq("R7 pending until read", 1'b1);
               rd_reg(3'd5, d); check("R7 new snapshot", d, pv);
               settle(1);
               check_irq("R7 inactive once equal", 1'b0);
            end
         end
      end

      // R8 active-high output
      wr_reg(3'd0, 8'h00); wr_reg(3'd1, 8'h00); set_pins(8'h00); rd_reg(3'd5, d);
      wr_reg(3'd3, 8'h01); pol = 1'b1;
      rd_reg(3'd3, d); check("R11 config readback", d, 8'h01);
      check("R8 idle low", {7'd0, irq}, 8'h00);
      wr_reg(3'd0, 8'hFF); settle(2);
      set_pins(8'h10);
      check("R8 pending high", {7'd0, irq}, 8'h01);
      rd_reg(3'd5, d); settle(1);
      check("R8 cleared low", {7'd0, irq}, 8'h00);
      wr_reg(3'd3, 8'h00); pol = 1'b0;

      // R9 clear and new trigger in the same cycle
      set_pins(8'h00); rd_reg(3'd5, d);
      set_pins(8'h01);
      check_irq("R9 setup pending", 1'b1);
      @(negedge clk); pins = 8'h03;
      @(posedge clk); @(posedge clk);
      @(negedge clk); rd = 1'b1; addr = 3'd5;
      @(negedge clk); rd = 1'b0;
      #1 check_irq("R9 inactive one cycle", 1'b0);
      @(negedge clk);
      check_irq("R9 pending next cycle", 1'b1);
      rd_reg(3'd4, d); check("R9 cause of late change", d, 8'h02);
      rd_reg(3'd5, d); check("R9 snapshot of late change", d, 8'h03);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule